// File: doc/BRIEF.md
# Merging Store Buffer with Read Bypass

This block sits between a write-through or write-back cache and the next level of memory. It takes stores from the cache side and holds them so the writer never waits on the slower memory. Each held entry stands for one aligned block of `WORDS` words and keeps one valid bit per word. A store to a block that already has an entry is folded into that entry, so a run of word stores to one block goes to memory as a single masked block write.

Cache read misses also pass through the buffer on their way to memory. A miss whose block is not held in the buffer goes to memory ahead of all queued writes. A miss whose block is held waits while the buffer drains oldest-first, until no entry for that block is left, and is then issued. When a miss evicts a dirty line, the cache writes the whole line into the buffer with every mask bit set. The read for the missing line then goes to memory first, and the line is written back later.

The memory side is a single request channel. Memory accepts the request shown on it in any cycle where `mem_gnt` is high. When the buffer is idle it drains eagerly, one entry per grant.

Top module: `store_gather_buf`

## Requirements
- R1: After reset the buffer holds no entry: `mem_req` and `rd_ack` are low and `wr_ready` is high.
- R2: A store whose block matches a held entry, other than the entry whose drain is granted in that same cycle, is merged into that entry and does not use a new one. Four single-word stores to one block give exactly one memory write, with `mem_wmask` = 4'b1111.
- R3: When a merged store covers a word that is already valid, the newer data replaces the older data for that word.
- R4: Each entry drains as exactly one memory write, in the order the entries were allocated. `mem_addr` carries the block address. Bit i of `mem_wmask` is word i's valid bit, and lane i of `mem_wdata` (bits i*DW +: DW) carries word i. A drain is requested whenever entries are held and no read is waiting. The entry is freed in the cycle its write is granted.
- R5: A waiting read whose block matches no held entry, while the buffer is not full, is presented at once with `mem_we`=0 and `mem_addr`=`rd_blk`, ahead of any queued writes.
- R6: A waiting read whose block matches a held entry is not issued. The oldest entries drain first until no entry matches, and then the read is issued.
- R7: `wr_ready` is low only when every entry is in use and no merge target exists. A store offered while `wr_ready` is low changes nothing and never reaches memory.
- R8: When the buffer is full and a read is waiting, the drain of the oldest entry is requested before the read.
- R9: One store may carry several mask bits, up to a whole dirty line. All of its masked words are written in one cycle. After an eviction has been written into the buffer, a read that does not match goes to memory before the line's write-back.
- R10: A store to the block of the entry whose drain is granted in the same cycle opens a new entry, so two writes reach memory.
- R11: `rd_ack` is high exactly in the cycles where a read request is presented and `mem_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store offered this cycle |
| wr_blk | input | BAW | Block address of the store |
| wr_mask | input | WORDS | Words of the block written by the store |
| wr_data | input | WORDS*DW | Store data, lane i holds word i |
| wr_ready | output | 1 | Store is taken this cycle if offered |
| rd_valid | input | 1 | Read miss waiting, held until acknowledged |
| rd_blk | input | BAW | Block address of the read miss |
| rd_ack | output | 1 | Read accepted by memory this cycle |
| mem_req | output | 1 | Request presented to memory |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | BAW | Block address of the request |
| mem_wdata | output | WORDS*DW | Write data, lane i holds word i |
| mem_wmask | output | WORDS | Per-word write enables |
| mem_gnt | input | 1 | Memory accepts the current request |

## Verification
The bench targets the cycle where a store hits the entry whose drain is being granted. A design that merged there would send stale data and silently drop the new word, so the count of memory writes comes out one short. Reads aimed at a queued block are checked against the drain order: a design without the address check would return old memory data, and one that drained the whole queue would issue extra writes before the read. The bench also fills the buffer completely and then checks three things. The writer is stalled unless its store can merge. A rejected store never shows up in memory. The drain wins over a waiting read, since giving the read priority there would block the stalled writer.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

    localparam int WB_WORDS = 4;
    localparam int WB_DW    = 32;
    localparam int WB_BAW   = 26;
    localparam int WB_DEPTH = 4;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_DRAIN = 2'd1,
        OP_READ  = 2'd2
    } mem_op_e;

    function automatic int ptr_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wbm_cam.sv
module wbm_cam #(
    parameter int N  = 4,
    parameter int KW = 26
) (
    input  logic [KW-1:0]         key,
    input  logic [N-1:0][KW-1:0]  tags,
    input  logic [N-1:0]          en,
    output logic [N-1:0]          hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = en[i] && (tags[i] == key);
    end
endmodule

// File: rtl/wbm_store.sv
module wbm_store #(
    parameter int DEPTH = 4,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    parameter int BAW   = 26,
    localparam int PW   = wbm_pkg::ptr_w(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         alloc,
    input  logic                         merge,
    input  logic [PW-1:0]                merge_idx,
    input  logic                         pop,
    input  logic [BAW-1:0]               wr_blk,
    input  logic [WORDS-1:0]             wr_mask,
    input  logic [WORDS*DW-1:0]          wr_data,
    output logic [DEPTH-1:0][BAW-1:0]    slot_blk,
    output logic [DEPTH-1:0]             slot_live,
    output logic [PW-1:0]                head_idx,
    output logic [BAW-1:0]               head_blk,
    output logic [WORDS-1:0]             head_mask,
    output logic [WORDS*DW-1:0]          head_data,
    output logic [CW-1:0]                fill,
    output logic                         full,
    output logic                         empty
);
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] fill_q;
    logic [DEPTH-1:0][WORDS-1:0]    mask_all;
    logic [DEPTH-1:0][WORDS*DW-1:0] data_all;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            fill_q <= '0;
        end else begin
            if (alloc) tail_q <= step_ptr(tail_q);
            if (pop)   head_q <= step_ptr(head_q);
            case ({alloc, pop})
                2'b10:   fill_q <= fill_q + CW'(1);
                2'b01:   fill_q <= fill_q - CW'(1);
                default: fill_q <= fill_q;
            endcase
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic                 live_r;
        logic [BAW-1:0]       blk_r;
        logic [WORDS-1:0]     mask_r;
        logic [WORDS*DW-1:0]  data_r;
        logic                 at_alloc, at_merge, at_pop;

        assign at_alloc = alloc && (tail_q == PW'(s));
        assign at_merge = merge && (merge_idx == PW'(s));
        assign at_pop   = pop && (head_q == PW'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                live_r <= 1'b0;
                blk_r  <= '0;
                mask_r <= '0;
            end else if (at_alloc) begin
                live_r <= 1'b1;
                blk_r  <= wr_blk;
                mask_r <= wr_mask;
            end else if (at_merge) begin
                mask_r <= mask_r | wr_mask;
            end else if (at_pop) begin
                live_r <= 1'b0;
                mask_r <= '0;
            end
        end

        always_ff @(posedge clk) begin
            for (int w = 0; w < WORDS; w++) begin
                if ((at_alloc || at_merge) && wr_mask[w])
                    data_r[w*DW +: DW] <= wr_data[w*DW +: DW];
            end
        end

        assign slot_live[s] = live_r;
        assign slot_blk[s]  = blk_r;
        assign mask_all[s]  = mask_r;
        assign data_all[s]  = data_r;
    end

    assign head_idx  = head_q;
    assign head_blk  = slot_blk[head_q];
    assign head_mask = mask_all[head_q];
    assign head_data = data_all[head_q];
    assign fill      = fill_q;
    assign full      = (fill_q == CW'(DEPTH));
    assign empty     = (fill_q == '0);
endmodule

// File: rtl/wbm_arb.sv
module wbm_arb
    import wbm_pkg::*;
(
    input  logic    rd_valid,
    input  logic    conflict,
    input  logic    full,
    input  logic    empty,
    input  logic    mem_gnt,
    output mem_op_e op,
    output logic    mem_req,
    output logic    mem_we,
    output logic    lock,
    output logic    rd_ack
);
    always_comb begin
        if (!empty && (!rd_valid || conflict || full))
            op = OP_DRAIN;
        else if (rd_valid)
            op = OP_READ;
        else
            op = OP_IDLE;
    end

    assign mem_req = (op != OP_IDLE);
    assign mem_we  = (op == OP_DRAIN);
    assign lock    = (op == OP_DRAIN) && mem_gnt;
    assign rd_ack  = (op == OP_READ) && mem_gnt;
endmodule

// File: rtl/store_gather_buf.sv
module store_gather_buf
    import wbm_pkg::*;
#(
    parameter int WORDS = WB_WORDS,
    parameter int DW    = WB_DW,
    parameter int BAW   = WB_BAW,
    parameter int DEPTH = WB_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    input  logic [BAW-1:0]       wr_blk,
    input  logic [WORDS-1:0]     wr_mask,
    input  logic [WORDS*DW-1:0]  wr_data,
    output logic                 wr_ready,
    input  logic                 rd_valid,
    input  logic [BAW-1:0]       rd_blk,
    output logic                 rd_ack,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [BAW-1:0]       mem_addr,
    output logic [WORDS*DW-1:0]  mem_wdata,
    output logic [WORDS-1:0]     mem_wmask,
    input  logic                 mem_gnt
);
    localparam int PW = ptr_w(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][BAW-1:0] slot_blk;
    logic [DEPTH-1:0]          slot_live;
    logic [DEPTH-1:0]          lock_vec, wr_hit, rd_hit;
    logic [PW-1:0]             head_idx, merge_idx;
    logic [BAW-1:0]            head_blk;
    logic [WORDS-1:0]          head_mask;
    logic [WORDS*DW-1:0]       head_data;
    logic [CW-1:0]             fill;
    logic                      full, empty, conflict, lock;
    logic                      merge_hit, accept, do_merge, do_alloc, do_pop;
    mem_op_e                   op;

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            lock_vec[i] = lock && (head_idx == PW'(i));
    end

    wbm_cam #(.N(DEPTH), .KW(BAW)) u_wr_cam (
        .key  (wr_blk),
        .tags (slot_blk),
        .en   (slot_live & ~lock_vec),
        .hit  (wr_hit)
    );

    wbm_cam #(.N(DEPTH), .KW(BAW)) u_rd_cam (
        .key  (rd_blk),
        .tags (slot_blk),
        .en   (slot_live),
        .hit  (rd_hit)
    );

    always_comb begin
        merge_hit = 1'b0;
        merge_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (wr_hit[i]) begin
                merge_hit = 1'b1;
                merge_idx = PW'(i);
            end
        end
    end

    assign conflict = rd_valid && (|rd_hit);

    wbm_arb u_arb (
        .rd_valid (rd_valid),
        .conflict (conflict),
        .full     (full),
        .empty    (empty),
        .mem_gnt  (mem_gnt),
        .op       (op),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .lock     (lock),
        .rd_ack   (rd_ack)
    );

    assign wr_ready = merge_hit || !full;
    assign accept   = wr_valid && wr_ready;
    assign do_merge = accept && merge_hit;
    assign do_alloc = accept && !merge_hit;
    assign do_pop   = mem_req && mem_we && mem_gnt;

    wbm_store #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW), .BAW(BAW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .alloc     (do_alloc),
        .merge     (do_merge),
        .merge_idx (merge_idx),
        .pop       (do_pop),
        .wr_blk    (wr_blk),
        .wr_mask   (wr_mask),
        .wr_data   (wr_data),
        .slot_blk  (slot_blk),
        .slot_live (slot_live),
        .head_idx  (head_idx),
        .head_blk  (head_blk),
        .head_mask (head_mask),
        .head_data (head_data),
        .fill      (fill),
        .full      (full),
        .empty     (empty)
    );

    assign mem_addr  = mem_we ? head_blk : rd_blk;
    assign mem_wmask = mem_we ? head_mask : '0;
    assign mem_wdata = head_data;
endmodule

// File: rtl/wbm_chk.sv
module wbm_chk #(
    parameter int WORDS = 4,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic             rd_ack,
    input logic             mem_req,
    input logic             mem_we,
    input logic [WORDS-1:0] mem_wmask,
    input logic             mem_gnt,
    input logic             conflict,
    input logic             full,
    input logic             empty,
    input logic [CW-1:0]    fill
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && !rd_valid) |-> !mem_req);

    // R4
    drain_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wmask != '0));

    // R4
    drain_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_gnt && !(wr_valid && wr_ready))
        |=> (fill == $past(fill) - CW'(1)));

    // R5
    read_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> rd_valid);

    // R6
    read_no_hazard_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !conflict);

    // R7
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    // R7
    stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready && !(mem_req && mem_we && mem_gnt)) |=> $stable(fill));

    // R8
    full_drain_first_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && full) |-> (mem_req && mem_we));

    // R11
    read_ack_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> (mem_req && !mem_we && mem_gnt));
endmodule

bind store_gather_buf wbm_chk #(.WORDS(WORDS), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .rd_ack    (rd_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wmask (mem_wmask),
    .mem_gnt   (mem_gnt),
    .conflict  (conflict),
    .full      (full),
    .empty     (empty),
    .fill      (fill)
);

// File: tb/store_gather_buf_bench.sv
`timescale 1ns/1ps
module store_gather_buf_bench;
    localparam int WORDS = 4;
    localparam int DW    = 32;
    localparam int BAW   = 26;
    localparam int DEPTH = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                wr_valid = 1'b0;
    logic [BAW-1:0]      wr_blk = '0;
    logic [WORDS-1:0]    wr_mask = '0;
    logic [WORDS*DW-1:0] wr_data = '0;
    logic                wr_ready;
    logic                rd_valid = 1'b0;
    logic [BAW-1:0]      rd_blk = '0;
    logic                rd_ack;
    logic                mem_req, mem_we;
    logic [BAW-1:0]      mem_addr;
    logic [WORDS*DW-1:0] mem_wdata;
    logic [WORDS-1:0]    mem_wmask;
    logic                mem_gnt = 1'b0;

    always #4 clk = ~clk;

    store_gather_buf u_store_gather_buf (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_blk(wr_blk), .wr_mask(wr_mask), .wr_data(wr_data),
        .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_blk(rd_blk), .rd_ack(rd_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_gnt(mem_gnt)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_wr  = 0;
    int n_rd  = 0;
    bit finished = 1'b0;

    // reference queue, index 0 is the oldest entry
    logic [BAW-1:0]   m_blk  [DEPTH];
    logic [WORDS-1:0] m_mask [DEPTH];
    logic [DW-1:0]    m_dat  [DEPTH][WORDS];
    int               m_cnt = 0;

    // values sampled in the last cycle
    bit             s_req, s_we, s_ready, s_ack;
    logic [BAW-1:0] s_addr;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cycle();
        bit conf, full, drain, rdiss, lock, erdy, eack, acc;
        int mi;
        string tag;
        #1;
        full = (m_cnt == DEPTH);
        conf = 1'b0;
        for (int i = 0; i < m_cnt; i++)
            if (rd_valid && m_blk[i] == rd_blk) conf = 1'b1;
        drain = (m_cnt > 0) && (!rd_valid || conf || full);
        rdiss = rd_valid && !drain;
        lock  = drain && mem_gnt;
        mi = -1;
        for (int i = (lock ? 1 : 0); i < m_cnt; i++)
            if (mi < 0 && m_blk[i] == wr_blk) mi = i;
        erdy = (mi >= 0) || (m_cnt < DEPTH);
        eack = rdiss && mem_gnt;

        if (conf) tag = "R6";
        else if (full && rd_valid) tag = "R8";
        else if (rd_valid) tag = "R5";
        else tag = "R4";

        check(mem_req === (drain || rdiss), tag, "mem_req", 64'(mem_req), 64'(drain || rdiss));
        if (drain) begin
            check(mem_we === 1'b1, tag, "mem_we drain", 64'(mem_we), 64'd1);
            check(mem_addr === m_blk[0], "R4", "drain addr", 64'(mem_addr), 64'(m_blk[0]));
            check(mem_wmask === m_mask[0], "R4", "drain mask", 64'(mem_wmask), 64'(m_mask[0]));
            for (int w = 0; w < WORDS; w++)
                if (m_mask[0][w])
                    check(mem_wdata[w*DW +: DW] === m_dat[0][w], "R3", "drain word",
                          64'(mem_wdata[w*DW +: DW]), 64'(m_dat[0][w]));
        end
        if (rdiss) begin
            check(mem_we === 1'b0, tag, "mem_we read", 64'(mem_we), 64'd0);
            check(mem_addr === rd_blk, tag, "read addr", 64'(mem_addr), 64'(rd_blk));
        end
        check(wr_ready === erdy, (mi >= 0) ? "R2" : "R7", "wr_ready", 64'(wr_ready), 64'(erdy));
        check(rd_ack === eack, "R11", "rd_ack", 64'(rd_ack), 64'(eack));

        s_req = mem_req; s_we = mem_we; s_ready = wr_ready; s_ack = rd_ack; s_addr = mem_addr;
        if (mem_req && mem_we && mem_gnt) n_wr++;
        if (rd_ack) n_rd++;
        acc = wr_valid && erdy;

        @(posedge clk);
        if (acc) begin
            if (mi >= 0) begin
                for (int w = 0; w < WORDS; w++)
                    if (wr_mask[w]) begin
                        m_mask[mi][w] = 1'b1;
                        m_dat[mi][w]  = wr_data[w*DW +: DW];
                    end
            end else begin
                m_blk[m_cnt]  = wr_blk;
                m_mask[m_cnt] = wr_mask;
                for (int w = 0; w < WORDS; w++)
                    if (wr_mask[w]) m_dat[m_cnt][w] = wr_data[w*DW +: DW];
                m_cnt++;
            end
        end
        if (drain && mem_gnt) begin
            for (int i = 0; i < m_cnt - 1; i++) begin
                m_blk[i]  = m_blk[i+1];
                m_mask[i] = m_mask[i+1];
                for (int w = 0; w < WORDS; w++) m_dat[i][w] = m_dat[i+1][w];
            end
            m_cnt--;
        end
        @(negedge clk);
    endtask

    task automatic drive(input bit wv, input logic [BAW-1:0] wb, input logic [WORDS-1:0] wm,
                         input logic [WORDS*DW-1:0] wd, input bit rv, input logic [BAW-1:0] rb,
                         input bit g);
        wr_valid = wv; wr_blk = wb; wr_mask = wm; wr_data = wd;
        rd_valid = rv; rd_blk = rb; mem_gnt = g;
        cycle();
    endtask

    task automatic store_word(input logic [BAW-1:0] b, input int w, input logic [DW-1:0] d,
                              input bit g);
        logic [WORDS*DW-1:0] lane;
        lane = '0;
        lane[w*DW +: DW] = d;
        drive(1'b1, b, WORDS'(1) << w, lane, 1'b0, '0, g);
    endtask

    task automatic flush();
        for (int i = 0; i < DEPTH + 2; i++) drive(1'b0, '0, '0, '0, 1'b0, '0, 1'b1);
    endtask

    initial begin
        int base;
        int unsigned seed_ret;
        bit rv;
        logic [BAW-1:0] rb;
        seed_ret = $urandom(32'd4242);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(wr_ready === 1'b1, "R1", "wr_ready after reset", 64'(wr_ready), 64'd1);
        check(mem_req === 1'b0, "R1", "mem_req after reset", 64'(mem_req), 64'd0);
        check(rd_ack === 1'b0, "R1", "rd_ack after reset", 64'(rd_ack), 64'd0);
        @(negedge clk);

        // R2: four word stores gather into one write
        base = n_wr;
        for (int w = 0; w < WORDS; w++) store_word(26'h40, w, 32'hA000 + w, 1'b0);
        flush();
        check(n_wr - base == 1, "R2", "writes for gathered block", 64'(n_wr - base), 64'd1);

        // R3: newer data for the same word wins (checked on drain data)
        store_word(26'h41, 2, 32'h1111, 1'b0);
        store_word(26'h41, 2, 32'h2222, 1'b0);
        flush();

        // R5: non-matching read bypasses queued writes
        store_word(26'h50, 0, 32'h5, 1'b0);
        store_word(26'h51, 1, 32'h6, 1'b0);
        drive(1'b0, '0, '0, '0, 1'b1, 26'h77, 1'b1);
        check(s_req && !s_we && s_addr == 26'h77, "R5", "read bypass", 64'(s_we), 64'd0);
        flush();

        // R9: dirty line written whole, then the read goes first
        base = n_wr;
        drive(1'b1, 26'h60, 4'b1111, {32'hD3, 32'hD2, 32'hD1, 32'hD0}, 1'b0, '0, 1'b0);
        drive(1'b0, '0, '0, '0, 1'b1, 26'h61, 1'b1);
        check(s_ack === 1'b1 && n_wr == base, "R9", "read before write-back", 64'(n_wr - base), 64'd0);
        flush();
        check(n_wr - base == 1, "R9", "line write-back count", 64'(n_wr - base), 64'd1);

        // R6: matching read waits for drain up to its block
        store_word(26'h70, 0, 32'h70, 1'b0);
        store_word(26'h71, 0, 32'h71, 1'b0);
        store_word(26'h72, 0, 32'h72, 1'b0);
        base = n_wr;
        for (int i = 0; i < 8; i++) begin
            drive(1'b0, '0, '0, '0, 1'b1, 26'h71, 1'b1);
            if (s_ack) break;
        end
        check(s_ack === 1'b1 && n_wr - base == 2, "R6", "writes ahead of read", 64'(n_wr - base), 64'd2);
        flush();

        // R8 and R7: full buffer
        for (int i = 0; i < DEPTH; i++) store_word(26'h80 + 26'(i), 0, 32'h80 + i, 1'b0);
        drive(1'b0, '0, '0, '0, 1'b1, 26'h99, 1'b0);
        check(s_req && s_we, "R8", "drain before read when full", 64'(s_we), 64'd1);
        base = n_wr;
        store_word(26'h9A, 0, 32'hBAD, 1'b0);
        check(s_ready === 1'b0, "R7", "stall when full", 64'(s_ready), 64'd0);
        store_word(26'h81, 3, 32'h813, 1'b0);
        check(s_ready === 1'b1, "R2", "merge while full", 64'(s_ready), 64'd1);
        flush();
        check(n_wr - base == DEPTH, "R7", "rejected store absent", 64'(n_wr - base), 64'(DEPTH));

        // R10: store to block whose drain is granted this cycle
        base = n_wr;
        store_word(26'hA0, 0, 32'hA0, 1'b0);
        store_word(26'hA0, 1, 32'hA1, 1'b1);
        flush();
        check(n_wr - base == 2, "R10", "new entry on granted block", 64'(n_wr - base), 64'd2);

        // constrained random traffic
        rv = 1'b0;
        rb = '0;
        for (int it = 0; it < 3000; it++) begin
            logic [WORDS-1:0] m;
            logic [WORDS*DW-1:0] d;
            bit wv, g;
            wv = ($urandom_range(0, 1) == 1);
            g  = ($urandom_range(0, 9) < 3);
            if ($urandom_range(0, 4) == 0) m = WORDS'($urandom_range(1, (1 << WORDS) - 1));
            else m = WORDS'(1) << $urandom_range(0, WORDS - 1);
            for (int w = 0; w < WORDS; w++) d[w*DW +: DW] = $urandom;
            if (!rv && $urandom_range(0, 7) == 0) begin
                rv = 1'b1;
                rb = 26'h100 + 26'($urandom_range(0, 5));
            end
            drive(wv, 26'h100 + 26'($urandom_range(0, 4)), m, d, rv, rb, g);
            if (s_ack) rv = 1'b0;
        end
        flush();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule